// File: doc/BRIEF.md
# Vector Predicate Result Packer

This unit takes a stream of per-element test results, one per accepted cycle, and packs them into 64-bit integer destination registers so they can later be used as predicate masks. A result is either a single bit or a four-bit nibble. Two 2-bit width codes are captured when a vector operation starts. The source-width code picks how many results share one destination element. The destination-width code picks the element size and, for nibble results, caps how many nibbles a group may hold. A scalar option gathers up to sixteen single-bit results into one register, one bit per element.

Each element also carries a predicate bit. When zeroing is enabled, a predicated-off element is written as zeros. When zeroing is disabled, its bits are left untouched, and the per-bit write enable is cleared for them. Partial register contents build up inside the unit. A register write is issued once per completed group, or once at the final element of the vector. The write carries a register offset, the data and a per-bit write enable. A start pulse opens each vector operation and a done pulse closes it.

Top module: `pk_packer`

## Requirements
- R1: After reset `busy`, `wr_en` and `done` are 0.
- R2: With `cfg_kind`=0 (single-bit results) and `cfg_scalar`=0, source-width codes 00/01/10/11 give groups of 1/2/4/8 results. Element i goes to register offset i/G, at bit i%G counted from the LSB, taken from `in_res[0]`.
- R3: With `cfg_kind`=0 and `cfg_scalar`=1, result i goes to bit i of register offset 0. A single write is issued at the last element.
- R4: With `cfg_kind`=1 (nibble results), destination codes 00/01/10/11 mean element widths W of 64/8/16/32 bits. Source codes 00/01/10/11 give groups of 1, 2, min(4,W/2) and min(8,W/2). A vector holds at most 16 elements.
- R5: Nibble result i is placed at bits 4·(i%G) to 4·(i%G)+3 of register offset i/G, with `in_res[k]` landing at bit 4·(i%G)+k.
- R6: Bits that hold no result are written as zero with write enable set. The enabled field is all 64 bits for single-bit results, and the lower max(W, 4·G) bits (at most 64) for nibble results.
- R7: With `cfg_zero`=1, an element whose `in_pred` is 0 has its result bits written as zero with write enable set, whatever `in_res` is.
- R8: With `cfg_zero`=0, an element whose `in_pred` is 0 has its result bits driven to zero and their write-enable bits cleared.
- R9: A write is issued in the cycle after the element that completes a group, or after the element marked `in_last`. Each write carries the register offset of that group.
- R10: `done` pulses together with the write of the last element, and `busy` falls in that same cycle. While `busy` is 0, `in_valid` has no effect.
- R11: `start` rises `busy` on the next cycle and discards any partial group and element count, so a restarted vector begins at offset 0 with empty contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a vector operation and captures the configuration |
| cfg_kind | input | 1 | 0: single-bit results, 1: nibble results |
| cfg_scalar | input | 1 | Single-bit results packed into one register |
| cfg_src_wc | input | 2 | Source-width code (group density) |
| cfg_dst_wc | input | 2 | Destination-width code (element size) |
| cfg_zero | input | 1 | Zeroing of predicated-off elements |
| in_valid | input | 1 | Element result present |
| in_res | input | NIB_W | Element result (bit 0 only for single-bit results) |
| in_pred | input | 1 | Destination predicate bit of the element |
| in_last | input | 1 | Marks the final element of the vector |
| busy | output | 1 | Vector operation in progress |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | IDX_W | Destination register offset |
| wr_data | output | REG_W | Packed register data |
| wr_bmask | output | REG_W | Per-bit write enable |
| done | output | 1 | Final write of the vector |

## Verification
The assertions assume that no vector offers more than sixteen elements between starts, since nibble packing is undefined beyond that length. They also assume that every vector is closed by an element flagged `in_last`, or cut off by a new `start`. The stimulus keeps to these assumptions by building each vector with at most sixteen elements and flagging the final one. The only exception is the restart case, which is deliberately interrupted by `start` after three elements. Idle cycles are inserted between elements at random, and `in_valid` is driven high while the unit is idle, so that the hold behaviour is also exercised.

// File: rtl/pk_pkg.sv
package pk_pkg;

   typedef enum logic {
      RES_BIT = 1'b0,
      RES_NIB = 1'b1
   } res_kind_e;

   typedef struct packed {
      res_kind_e  kind;
      logic       scalar;
      logic [1:0] src_wc;
      logic [1:0] dst_wc;
      logic       zero_en;
   } pack_cfg_t;

   function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
      return (a < b) ? a : b;
   endfunction

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // destination element size selected by the destination-width code
   function automatic int unsigned elem_bits(input logic [1:0] dst_wc, input int unsigned reg_w);
      case (dst_wc)
         2'b00:   return reg_w;
         2'b01:   return 8;
         2'b10:   return 16;
         default: return 32;
      endcase
   endfunction

   // number of results sharing one destination register
   function automatic int unsigned group_len(input pack_cfg_t c, input int unsigned reg_w,
                                             input int unsigned vl_max);
      int unsigned half;
      half = elem_bits(c.dst_wc, reg_w) / 2;
      if (c.kind == RES_BIT) begin
         if (c.scalar) return vl_max;
         return 32'd1 << c.src_wc;
      end
      case (c.src_wc)
         2'b00:   return 1;
         2'b01:   return 2;
         2'b10:   return min_u(4, half);
         default: return min_u(8, half);
      endcase
   endfunction

   // width of the written field (results plus zero padding)
   function automatic int unsigned field_bits(input pack_cfg_t c, input int unsigned reg_w,
                                              input int unsigned nib_w, input int unsigned vl_max);
      if (c.kind == RES_BIT) return reg_w;
      return min_u(reg_w, max_u(elem_bits(c.dst_wc, reg_w), nib_w * group_len(c, reg_w, vl_max)));
   endfunction

endpackage

// File: rtl/pk_cfg_decode.sv
module pk_cfg_decode
   import pk_pkg::*;
#(
   parameter int unsigned REG_W  = 64,
   parameter int unsigned VL_MAX = 16,
   parameter int unsigned NIB_W  = 4,
   parameter int unsigned GS_W   = 5
) (
   input  pack_cfg_t         cfg,
   output logic [GS_W-1:0]   grp_last,
   output logic [REG_W-1:0]  field_mask
);

   int unsigned glen;
   int unsigned fbits;

   always_comb begin
      glen     = group_len(cfg, REG_W, VL_MAX);
      fbits    = field_bits(cfg, REG_W, NIB_W, VL_MAX);
      grp_last = GS_W'(glen - 1);
   end

   for (genvar b = 0; b < REG_W; b++) begin : g_field
      localparam int unsigned BPOS = b;
      assign field_mask[b] = (fbits > BPOS);
   end

endmodule

// File: rtl/pk_lane_place.sv
module pk_lane_place
   import pk_pkg::*;
#(
   parameter int unsigned REG_W = 64,
   parameter int unsigned NIB_W = 4,
   parameter int unsigned GS_W  = 5
) (
   input  res_kind_e         kind,
   input  logic [GS_W-1:0]   off,
   input  logic [NIB_W-1:0]  res,
   input  logic              pred,
   input  logic              zero_en,
   output logic [REG_W-1:0]  set_bits,
   output logic [REG_W-1:0]  clr_bits
);

   logic drop;
   assign drop = ~pred & ~zero_en;

   for (genvar b = 0; b < REG_W; b++) begin : g_lane
      localparam int unsigned LANE = b / NIB_W;
      localparam int unsigned SUB  = b % NIB_W;
      localparam int unsigned BPOS = b;
      logic hit;
      logic val;
      assign hit = (kind == RES_NIB) ? (32'(off) == LANE) : (32'(off) == BPOS);
      assign val = (kind == RES_NIB) ? res[SUB] : res[0];
      assign set_bits[b] = hit & pred & val;
      assign clr_bits[b] = hit & drop;
   end

endmodule

// File: rtl/pk_accum.sv
module pk_accum #(
   parameter int unsigned REG_W = 64,
   parameter int unsigned IDX_W = 4,
   parameter int unsigned GS_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              in_valid,
   input  logic              in_last,
   input  logic [GS_W-1:0]   grp_last,
   input  logic [REG_W-1:0]  field_mask,
   input  logic [REG_W-1:0]  set_bits,
   input  logic [REG_W-1:0]  clr_bits,
   output logic [GS_W-1:0]   off_cnt,
   output logic              busy,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  wr_bmask,
   output logic              done
);

   logic [IDX_W-1:0] reg_cnt;
   logic [REG_W-1:0] acc_data;
   logic [REG_W-1:0] acc_clr;
   logic             accept;
   logic             flush;
   logic [REG_W-1:0] nxt_data;
   logic [REG_W-1:0] nxt_clr;

   assign accept   = busy & in_valid & ~start;
   assign flush    = accept & ((off_cnt == grp_last) | in_last);
   assign nxt_data = acc_data | set_bits;
   assign nxt_clr  = acc_clr | clr_bits;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         off_cnt  <= '0;
         reg_cnt  <= '0;
         acc_data <= '0;
         acc_clr  <= '0;
         wr_en    <= 1'b0;
         wr_idx   <= '0;
         wr_data  <= '0;
         wr_bmask <= '0;
         done     <= 1'b0;
      end else begin
         wr_en <= flush;
         done  <= accept & in_last;
         if (start) begin
            busy     <= 1'b1;
            off_cnt  <= '0;
            reg_cnt  <= '0;
            acc_data <= '0;
            acc_clr  <= '0;
         end else if (accept) begin
            if (flush) begin
               wr_idx   <= reg_cnt;
               wr_data  <= nxt_data;
               wr_bmask <= field_mask & ~nxt_clr;
               off_cnt  <= '0;
               reg_cnt  <= reg_cnt + 1'b1;
               acc_data <= '0;
               acc_clr  <= '0;
            end else begin
               off_cnt  <= off_cnt + 1'b1;
               acc_data <= nxt_data;
               acc_clr  <= nxt_clr;
            end
            if (in_last) busy <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pk_packer.sv
module pk_packer
   import pk_pkg::*;
#(
   parameter int unsigned REG_W  = 64,
   parameter int unsigned VL_MAX = 16,
   parameter int unsigned NIB_W  = 4,
   localparam int unsigned IDX_W = $clog2(VL_MAX),
   localparam int unsigned GS_W  = $clog2(VL_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cfg_kind,
   input  logic              cfg_scalar,
   input  logic [1:0]        cfg_src_wc,
   input  logic [1:0]        cfg_dst_wc,
   input  logic              cfg_zero,
   input  logic              in_valid,
   input  logic [NIB_W-1:0]  in_res,
   input  logic              in_pred,
   input  logic              in_last,
   output logic              busy,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  wr_bmask,
   output logic              done
);

   if (VL_MAX < 8) begin : g_bad_vl
      $error("VL_MAX must cover the densest group of eight");
   end
   if (VL_MAX > REG_W) begin : g_bad_scalar
      $error("scalar packing needs VL_MAX <= REG_W");
   end
   if (NIB_W * 8 > REG_W || REG_W < 32) begin : g_bad_reg
      $error("register too narrow for the densest nibble group");
   end

   pack_cfg_t         cfg_q;
   logic [GS_W-1:0]   grp_last;
   logic [REG_W-1:0]  field_mask;
   logic [REG_W-1:0]  set_bits;
   logic [REG_W-1:0]  clr_bits;
   logic [GS_W-1:0]   off_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (start) begin
         cfg_q.kind    <= res_kind_e'(cfg_kind);
         cfg_q.scalar  <= cfg_scalar;
         cfg_q.src_wc  <= cfg_src_wc;
         cfg_q.dst_wc  <= cfg_dst_wc;
         cfg_q.zero_en <= cfg_zero;
      end
   end

   pk_cfg_decode #(
      .REG_W(REG_W), .VL_MAX(VL_MAX), .NIB_W(NIB_W), .GS_W(GS_W)
   ) u_dec (
      .cfg        (cfg_q),
      .grp_last   (grp_last),
      .field_mask (field_mask)
   );

   pk_lane_place #(
      .REG_W(REG_W), .NIB_W(NIB_W), .GS_W(GS_W)
   ) u_place (
      .kind     (cfg_q.kind),
      .off      (off_cnt),
      .res      (in_res),
      .pred     (in_pred),
      .zero_en  (cfg_q.zero_en),
      .set_bits (set_bits),
      .clr_bits (clr_bits)
   );

   pk_accum #(
      .REG_W(REG_W), .IDX_W(IDX_W), .GS_W(GS_W)
   ) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .in_valid   (in_valid),
      .in_last    (in_last),
      .grp_last   (grp_last),
      .field_mask (field_mask),
      .set_bits   (set_bits),
      .clr_bits   (clr_bits),
      .off_cnt    (off_cnt),
      .busy       (busy),
      .wr_en      (wr_en),
      .wr_idx     (wr_idx),
      .wr_data    (wr_data),
      .wr_bmask   (wr_bmask),
      .done       (done)
   );

endmodule

// File: rtl/pk_checker.sv
module pk_checker #(
   parameter int unsigned REG_W  = 64,
   parameter int unsigned VL_MAX = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             in_valid,
   input logic             in_last,
   input logic             busy,
   input logic             wr_en,
   input logic             done,
   input logic [REG_W-1:0] wr_data,
   input logic [REG_W-1:0] wr_bmask
);

   localparam int unsigned CNT_W = $clog2(VL_MAX + 2);

   logic [CNT_W-1:0] seen;
   logic             take;

   assign take = busy && in_valid && !start;

   always_ff @(posedge clk) begin
      if (!rst_n)    seen <= '0;
      else if (start) seen <= '0;
      else if (take && seen <= CNT_W'(VL_MAX)) seen <= seen + 1'b1;
   end

   AST_VL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (seen < CNT_W'(VL_MAX)));                                  // R4
   AST_DONE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> wr_en);                                                    // R10
   AST_WRITE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(take));                                             // R9
   AST_HELD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ((wr_data & ~wr_bmask) == '0));                           // R8
   AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (take && in_last) |=> (done && !busy));                             // R10
   AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy && !wr_en));                                        // R11
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> (!wr_en && !done));                                       // R10

endmodule

bind pk_packer pk_checker #(.REG_W(REG_W), .VL_MAX(VL_MAX)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .in_valid (in_valid),
   .in_last  (in_last),
   .busy     (busy),
   .wr_en    (wr_en),
   .done     (done),
   .wr_data  (wr_data),
   .wr_bmask (wr_bmask)
);

// File: tb/sim_pk_packer.sv
`timescale 1ns/1ps
module sim_pk_packer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        cfg_kind = 1'b0;
   logic        cfg_scalar = 1'b0;
   logic [1:0]  cfg_src_wc = 2'b00;
   logic [1:0]  cfg_dst_wc = 2'b00;
   logic        cfg_zero = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  in_res = 4'h0;
   logic        in_pred = 1'b0;
   logic        in_last = 1'b0;
   logic        busy;
   logic        wr_en;
   logic [3:0]  wr_idx;
   logic [63:0] wr_data;
   logic [63:0] wr_bmask;
   logic        done;

   always #4 clk = ~clk;

   pk_packer u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_kind(cfg_kind), .cfg_scalar(cfg_scalar),
      .cfg_src_wc(cfg_src_wc), .cfg_dst_wc(cfg_dst_wc), .cfg_zero(cfg_zero),
      .in_valid(in_valid), .in_res(in_res), .in_pred(in_pred), .in_last(in_last),
      .busy(busy), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .wr_bmask(wr_bmask), .done(done)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   int    n_wr  = 0;
   bit    cmp_on = 1'b0;
   bit    fin = 1'b0;
   string cur_req = "R1";

   task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   function automatic int ref_width(input logic [1:0] d);
      case (d)
         2'b00: return 64;
         2'b01: return 8;
         2'b10: return 16;
         default: return 32;
      endcase
   endfunction

   function automatic int ref_group(input bit k, input bit sc, input logic [1:0] s, input logic [1:0] d);
      int h;
      h = ref_width(d) / 2;
      if (!k) return sc ? 16 : (1 << s);
      if (s == 2'b00) return 1;
      if (s == 2'b01) return 2;
      if (s == 2'b10) return (h < 4) ? h : 4;
      return (h < 8) ? h : 8;
   endfunction

   function automatic logic [63:0] ref_field(input bit k, input int g, input logic [1:0] d);
      int f;
      if (!k) return '1;
      f = ref_width(d);
      if (4 * g > f) f = 4 * g;
      if (f >= 64) return '1;
      return (64'd1 << f) - 64'd1;
   endfunction

   bit          m_busy = 0, m_kind = 0, m_sc = 0, m_zero = 0;
   logic [1:0]  m_src = 0, m_dst = 0;
   int          m_i = 0;
   logic [63:0] m_acc = 0, m_clr = 0;
   bit          e_wr = 0, e_done = 0, e_busy = 0;
   int          e_idx = 0;
   logic [63:0] e_data = 0, e_mask = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_i = 0; m_acc = 0; m_clr = 0;
         e_wr = 0; e_done = 0; e_busy = 0;
         m_kind = 0; m_sc = 0; m_src = 0; m_dst = 0; m_zero = 0;
      end else begin
         e_wr = 0; e_done = 0;
         if (start) begin
            m_busy = 1; m_i = 0; m_acc = 0; m_clr = 0;
            m_kind = cfg_kind; m_sc = cfg_scalar; m_src = cfg_src_wc;
            m_dst = cfg_dst_wc; m_zero = cfg_zero;
         end else if (m_busy && in_valid) begin
            int g, off, wk, base;
            g    = ref_group(m_kind, m_sc, m_src, m_dst);
            off  = m_i % g;
            wk   = m_kind ? 4 : 1;
            base = m_kind ? 4 * off : off;
            for (int k = 0; k < wk; k++) begin
               if (in_pred)     m_acc[base + k] = in_res[k];
               else if (m_zero) m_acc[base + k] = 1'b0;
               else             m_clr[base + k] = 1'b1;
            end
            if (off == g - 1 || in_last) begin
               e_wr = 1; e_idx = m_i / g; e_data = m_acc;
               e_mask = ref_field(m_kind, g, m_dst) & ~m_clr;
               m_acc = 0; m_clr = 0;
            end
            if (in_last) begin
               e_done = 1; m_busy = 0;
            end
            m_i++;
         end
         e_busy = m_busy;
      end
   end

   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         chk(busy == e_busy, "busy", 64'(busy), 64'(e_busy));
         chk(wr_en == e_wr, "wr_en", 64'(wr_en), 64'(e_wr));
         chk(done == e_done, "done", 64'(done), 64'(e_done));
         if (e_wr) begin
            chk(int'(wr_idx) == e_idx, "wr_idx", 64'(wr_idx), 64'(e_idx));
            chk(wr_data == e_data, "wr_data", wr_data, e_data);
            chk(wr_bmask == e_mask, "wr_bmask", wr_bmask, e_mask);
         end
         if (wr_en) n_wr++;
      end
   end

   // ---------------- stimulus ----------------
   task automatic run_vec(input bit k, input bit sc, input logic [1:0] s, input logic [1:0] d,
                          input bit z, input int n, input bit rnd_pred, input bit gaps);
      int g, exp_wr;
      @(negedge clk);
      cfg_kind = k; cfg_scalar = sc; cfg_src_wc = s; cfg_dst_wc = d; cfg_zero = z;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n_wr = 0;
      for (int i = 0; i < n; i++) begin
         if (gaps && ($urandom % 3 == 0)) begin
            in_valid = 1'b0;
            @(negedge clk);
         end
         in_valid = 1'b1;
         in_res   = 4'($urandom);
         in_pred  = rnd_pred ? 1'($urandom) : 1'b1;
         in_last  = (i == n - 1);
         @(negedge clk);
      end
      in_valid = 1'b0; in_last = 1'b0;
      @(negedge clk);
      @(negedge clk);
      g = ref_group(k, sc, s, d);
      exp_wr = (n + g - 1) / g;
      chk(n_wr == exp_wr, "write count (R9)", 64'(n_wr), 64'(exp_wr));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      chk(busy == 1'b0, "reset busy", 64'(busy), 64'd0);
      chk(wr_en == 1'b0, "reset wr_en", 64'(wr_en), 64'd0);
      chk(done == 1'b0, "reset done", 64'(done), 64'd0);
      cmp_on = 1'b1;

      cur_req = "R2";
      for (int s = 0; s < 4; s++) run_vec(0, 0, 2'(s), 2'b00, 0, 16, 0, 0);
      run_vec(0, 0, 2'b10, 2'b11, 0, 11, 0, 1);

      cur_req = "R3";
      run_vec(0, 1, 2'b00, 2'b00, 0, 16, 0, 0);
      run_vec(0, 1, 2'b11, 2'b01, 0, 5, 0, 1);

      cur_req = "R4";
      for (int d = 0; d < 4; d++)
         for (int s = 0; s < 4; s++) run_vec(1, 0, 2'(s), 2'(d), 0, 16, 0, 0);

      cur_req = "R5";
      run_vec(1, 0, 2'b11, 2'b00, 0, 13, 0, 1);
      run_vec(1, 1, 2'b10, 2'b10, 0, 9, 0, 0);

      cur_req = "R6";
      run_vec(0, 0, 2'b11, 2'b00, 0, 5, 0, 0);
      run_vec(1, 0, 2'b00, 2'b01, 0, 3, 0, 0);
      run_vec(1, 0, 2'b01, 2'b10, 0, 1, 0, 0);

      cur_req = "R7";
      for (int r = 0; r < 4; r++) run_vec(1'(r), 0, 2'(r), 2'(3 - r), 1, 16, 1, 1);

      cur_req = "R8";
      for (int r = 0; r < 4; r++) run_vec(1'(r + 1), 0, 2'(3 - r), 2'(r), 0, 16, 1, 1);
      run_vec(0, 1, 2'b00, 2'b00, 0, 16, 1, 0);

      cur_req = "R9";
      run_vec(1, 0, 2'b10, 2'b11, 1, 15, 1, 1);
      run_vec(0, 0, 2'b01, 2'b00, 0, 7, 1, 1);

      cur_req = "R10";
      @(negedge clk);
      in_valid = 1'b1; in_last = 1'b1; in_res = 4'hF; in_pred = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(wr_en == 1'b0, "idle write", 64'(wr_en), 64'd0);
         chk(busy == 1'b0, "idle busy", 64'(busy), 64'd0);
      end
      in_valid = 1'b0; in_last = 1'b0;
      run_vec(1, 0, 2'b11, 2'b11, 0, 8, 0, 0);

      cur_req = "R11";
      @(negedge clk);
      cfg_kind = 1'b1; cfg_scalar = 1'b0; cfg_src_wc = 2'b11; cfg_dst_wc = 2'b00; cfg_zero = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 3; i++) begin
         in_valid = 1'b1; in_res = 4'($urandom); in_pred = 1'b1; in_last = 1'b0;
         @(negedge clk);
      end
      in_valid = 1'b0;
      run_vec(1, 0, 2'b11, 2'b00, 0, 4, 0, 0);
      run_vec(0, 0, 2'b10, 2'b00, 1, 6, 1, 0);

      fin = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!fin) begin
         n_chk++;
         n_bad++;
         $display("FAIL %s watchdog actual=hung expected=finished", cur_req);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule